// File: doc/BRIEF.md
# Serial Management Frame Responder

This block answers serial management frames from the device side of the link. It runs in the system clock domain and treats the management clock as a sampled input. On each rising edge of that clock it shifts one bit into a 32-bit history. A data bit counts as a one only when the data line is high and the input-valid qualifier is also high.

A run of 32 ones in the history aligns the block to the frame. The next 16 bits are taken as a header. A read header loads the addressed entry of an internal 32-entry, 16-bit register file and then drives it out, most significant bit first. A write header takes the 16 bits that follow, stores them in the addressed entry and reports the store on a one-cycle strobe with its address and data.

The header's device address field is accepted and not compared, so every frame is answered. Entries 2 and 3 come out of reset holding fixed identifier words. All other entries reset to zero.

Top module: `mdio_responder`

## Requirements
- R1: The data line is sampled only on a rising edge of `mdc`, seen as `mdc` high in a system clock cycle after it was low. The sampled bit is 1 only when `mdio_in` and `mdio_oe` are both high. Changes on `mdio_in` while `mdc` stays high have no effect.
- R2: Each time the last 32 sampled bits are all ones, the block realigns so that the next 16 bits form a header. A preamble longer than 32 ones still aligns. Only 31 ones after a zero does not align, and the frame that follows gets no response.
- R3: The header is sent first bit first and reads as a 16-bit word. Bits 15:14 are the start code, 13:12 the opcode, 11:7 the device address, 6:2 the register index and 1:0 the turnaround.
- R4: A header with start 01, opcode 01 and turnaround exactly 10 is a write. The 16 bits that follow, first bit as bit 15, are stored at the register index. On the last of those bits, `wr_en` pulses for one clock cycle, with the index on `wr_addr` and the word on `wr_data`.
- R5: A header with start 01, opcode 10 and turnaround bit 0 equal to 0 is a read, so turnaround 00 and 10 are both accepted. Every other header, including a write with turnaround 11 or 00, causes no output, no store and no strobe.
- R6: After an accepted read header, the next 16 rising edges of `mdc` each present one bit of the addressed entry on `mdio_out`, bit 15 first. Each bit holds until the following rising edge.
- R7: Reset sets every register entry to zero, except entry 2, which becomes 0x0022, and entry 3, which becomes 0x161A.
- R8: The device address field does not affect which frames are answered or which entry is used.
- R9: `mdio_out` is low in reset, at the header decode edge, outside the 16 read-data edges, and on the first rising edge after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock, sampled in the system clock domain |
| mdio_in | input | 1 | Management data toward the block |
| mdio_oe | input | 1 | Qualifier; a sampled bit is 1 only when this is high |
| mdio_out | output | 1 | Read data toward the controller |
| wr_en | output | 1 | One-cycle strobe for a completed write |
| wr_addr | output | 5 | Register index of the completed write |
| wr_data | output | 16 | Word stored by the completed write |

## Verification
The bench builds the block with its defaults: 16-bit entries, 32 entries, and the identifier words 0x0022 and 0x161A. With 16-bit entries the alignment window is exactly 32 bits. That makes the difference between a 31-one and a 45-one preamble observable. The 32 entries put both the top index 31 and the two identifier entries within reach of the directed reads.

// File: rtl/mdio_responder.sv
module mdio_responder #(
  parameter int REG_W = 16,
  parameter int REG_N = 32,
  parameter logic [REG_W-1:0] ID_HI = 16'h0022,
  parameter logic [REG_W-1:0] ID_LO = 16'h161A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mdc,
  input  logic                     mdio_in,
  input  logic                     mdio_oe,
  output logic                     mdio_out,
  output logic                     wr_en,
  output logic [$clog2(REG_N)-1:0] wr_addr,
  output logic [REG_W-1:0]         wr_data
);
  localparam int HDR_W  = 16;
  localparam int SYNC_W = HDR_W + REG_W;
  localparam int AW     = $clog2(REG_N);
  localparam int CW     = $clog2(SYNC_W) + 2;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} st_e;

  logic                 mdc_d;
  logic                 rise;
  logic [SYNC_W-1:0]    sh;
  logic [SYNC_W-1:0]    sh_nx;
  logic signed [CW-1:0] cnt;
  logic signed [CW-1:0] cnt_eff;
  st_e                  st;
  st_e                  st_dec;
  logic [REG_W-1:0]     dout;
  logic [AW-1:0]        rsel;
  logic [REG_W-1:0]     regs [REG_N];
  logic                 at_dec, dec_wr, dec_rd, shift_rd, fin;

  assign rise    = mdc & ~mdc_d;
  assign sh_nx   = {sh[SYNC_W-2:0], mdio_in & mdio_oe};
  assign cnt_eff = (&sh_nx) ? CW'(SYNC_W) : cnt;
  assign at_dec  = (cnt_eff == CW'(REG_W));
  assign fin     = (cnt_eff == '0);

  assign dec_wr = (sh_nx[15:14] == 2'b01) && (sh_nx[13:12] == 2'b01) && (sh_nx[1:0] == 2'b10);
  assign dec_rd = (sh_nx[15:14] == 2'b01) && (sh_nx[13:12] == 2'b10) && !sh_nx[0];

  always_comb begin
    st_dec = st;
    if (at_dec) st_dec = dec_wr ? ST_WR : (dec_rd ? ST_RD : ST_IDLE);
  end

  assign shift_rd = (st_dec == ST_RD) && (cnt_eff < CW'(REG_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_d    <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      st       <= ST_IDLE;
      dout     <= '0;
      rsel     <= '0;
      mdio_out <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      for (int i = 0; i < REG_N; i++)
        regs[i] <= (i == 2) ? ID_HI : ((i == 3) ? ID_LO : '0);
    end else begin
      mdc_d <= mdc;
      wr_en <= 1'b0;
      if (rise) begin
        sh       <= sh_nx;
        cnt      <= (cnt_eff < 0) ? cnt_eff : cnt_eff - CW'(1);
        st       <= fin ? ST_IDLE : st_dec;
        mdio_out <= shift_rd & dout[REG_W-1];
        if (at_dec && (dec_wr || dec_rd)) rsel <= sh_nx[2 +: AW];
        if (at_dec && dec_rd)
          dout <= regs[sh_nx[2 +: AW]];
        else if (shift_rd)
          dout <= {dout[REG_W-2:0], 1'b0};
        if (fin && st_dec == ST_WR) begin
          regs[rsel] <= sh_nx[REG_W-1:0];
          wr_en      <= 1'b1;
          wr_addr    <= rsel;
          wr_data    <= sh_nx[REG_W-1:0];
        end
      end
    end
  end

  a_r1_state_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(st));

  a_r1_out_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(mdio_out));

  a_r4_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(st) == ST_WR) && ($past(cnt) == '0));

  a_r5_read_at_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_RD) |-> $past(cnt_eff) == CW'(REG_W));

  a_r9_out_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_out) |-> $past(st) == ST_RD);
endmodule

// File: tb/mdio_responder_tb_top.sv
`timescale 1ns/1ps
module mdio_responder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, mdio_in = 1'b0, mdio_oe = 1'b0;
  logic        mdio_out, wr_en;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;

  always #2.5 clk = ~clk;

  mdio_responder dut_i (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in), .mdio_oe(mdio_oe),
    .mdio_out(mdio_out), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int errs = 0, chks = 0, wr_seen = 0;
  logic [4:0]  last_addr = '0;
  logic [15:0] last_data = '0;
  bit done = 0;

  always @(negedge clk) if (wr_en) begin
    wr_seen++;
    last_addr = wr_addr;
    last_data = wr_data;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic oe, input logic gl);
    @(negedge clk);
    mdio_in = b; mdio_oe = oe; mdc = 1'b0;
    repeat (3) @(negedge clk);
    mdc = 1'b1;
    @(negedge clk);
    if (gl) mdio_in = ~b;
    repeat (3) @(negedge clk);
  endtask

  task automatic preamble(input int n, input logic oe);
    for (int k = 0; k < n; k++) send_bit(1'b1, oe, 1'b0);
  endtask

  task automatic run_frame(input logic [15:0] hdr, input logic [15:0] dat, input logic doe,
                           input logic gl, output logic [15:0] got,
                           output logic pre_hi, output logic post_hi);
    for (int k = 15; k >= 0; k--) send_bit(hdr[k], 1'b1, gl);
    pre_hi = mdio_out;
    got = '0;
    for (int k = 15; k >= 0; k--) begin
      send_bit(dat[k], doe, gl);
      got = {got[14:0], mdio_out};
    end
    send_bit(1'b0, 1'b0, 1'b0);
    post_hi = mdio_out;
  endtask

  function automatic logic [15:0] hdr_of(input logic [1:0] s, input logic [1:0] o,
                                         input logic [4:0] p, input logic [4:0] r,
                                         input logic [1:0] t);
    return {s, o, p, r, t};
  endfunction

  // {kind, start, op, phy, reg, ta, wdata, expected}; kind 1 write, 2 read, 0 rejected
  localparam int NV = 16;
  localparam logic [49:0] VEC [NV] = '{
    {2'd2, 2'b01, 2'b10, 5'd1,  5'd2,  2'b10, 16'h0000, 16'h0022},
    {2'd2, 2'b01, 2'b10, 5'd0,  5'd3,  2'b00, 16'h0000, 16'h161A},
    {2'd2, 2'b01, 2'b10, 5'd4,  5'd5,  2'b10, 16'h0000, 16'h0000},
    {2'd1, 2'b01, 2'b01, 5'd31, 5'd5,  2'b10, 16'hA5C3, 16'h0000},
    {2'd2, 2'b01, 2'b10, 5'd7,  5'd5,  2'b10, 16'h0000, 16'hA5C3},
    {2'd0, 2'b01, 2'b01, 5'd2,  5'd5,  2'b11, 16'h1234, 16'h0000},
    {2'd2, 2'b01, 2'b10, 5'd2,  5'd5,  2'b10, 16'h0000, 16'hA5C3},
    {2'd0, 2'b01, 2'b10, 5'd2,  5'd2,  2'b01, 16'h0000, 16'h0000},
    {2'd0, 2'b00, 2'b10, 5'd2,  5'd2,  2'b10, 16'h0000, 16'h0000},
    {2'd0, 2'b01, 2'b11, 5'd2,  5'd2,  2'b10, 16'h0000, 16'h0000},
    {2'd1, 2'b01, 2'b01, 5'd3,  5'd31, 2'b10, 16'h8001, 16'h0000},
    {2'd2, 2'b01, 2'b10, 5'd3,  5'd31, 2'b00, 16'h0000, 16'h8001},
    {2'd1, 2'b01, 2'b01, 5'd0,  5'd2,  2'b10, 16'hFFFF, 16'h0000},
    {2'd2, 2'b01, 2'b10, 5'd0,  5'd2,  2'b10, 16'h0000, 16'hFFFF},
    {2'd0, 2'b01, 2'b01, 5'd0,  5'd5,  2'b00, 16'h5555, 16'h0000},
    {2'd2, 2'b01, 2'b10, 5'd0,  5'd5,  2'b10, 16'h0000, 16'hA5C3}
  };

  initial begin
    #500000;
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic pre, post;
    int w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 reset mdio_out", 32'(mdio_out), 0);
    chk("R4 reset wr_en", 32'(wr_en), 0);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      w0 = wr_seen;
      preamble(32, 1'b1);
      run_frame(v[47:32], v[31:16], v[49:48] != 2'd2, 1'b0, got, pre, post);
      chk("R9 decode edge low", 32'(pre), 0);
      chk("R9 after data low", 32'(post), 0);
      case (v[49:48])
        2'd1: begin
          chk("R3 R4 write strobe count", 32'(wr_seen - w0), 1);
          chk("R4 write addr", 32'(last_addr), 32'(v[38:34]));
          chk("R4 write data", 32'(last_data), 32'(v[31:16]));
        end
        2'd2: begin
          chk("R3 R6 read data", 32'(got), 32'(v[15:0]));
          chk("R6 no strobe on read", 32'(wr_seen - w0), 0);
        end
        default: begin
          chk("R5 rejected no output", 32'(got), 0);
          chk("R5 rejected no strobe", 32'(wr_seen - w0), 0);
        end
      endcase
    end

    // R1: qualifier low makes the preamble zeros, so nothing aligns
    w0 = wr_seen;
    preamble(32, 1'b0);
    run_frame(hdr_of(2'b01, 2'b10, 5'd0, 5'd2, 2'b10), 16'h0, 1'b0, 1'b0, got, pre, post);
    chk("R1 qualifier low blocks alignment", 32'(got), 0);

    // R1: data flipped while mdc is high must not matter
    preamble(32, 1'b1);
    run_frame(hdr_of(2'b01, 2'b01, 5'd0, 5'd7, 2'b10), 16'h3C5A, 1'b1, 1'b1, got, pre, post);
    chk("R1 glitch write data", 32'(last_data), 32'h3C5A);
    chk("R1 glitch write addr", 32'(last_addr), 7);

    // R2: long preamble still aligns
    preamble(45, 1'b1);
    run_frame(hdr_of(2'b01, 2'b10, 5'd0, 5'd7, 2'b10), 16'h0, 1'b0, 1'b0, got, pre, post);
    chk("R2 long preamble read", 32'(got), 32'h3C5A);

    // R2: 31 ones after a zero do not align
    preamble(31, 1'b1);
    run_frame(hdr_of(2'b01, 2'b10, 5'd0, 5'd7, 2'b10), 16'h0, 1'b0, 1'b0, got, pre, post);
    chk("R2 short preamble ignored", 32'(got), 0);

    // R8: different device addresses reach the same entry
    preamble(32, 1'b1);
    run_frame(hdr_of(2'b01, 2'b01, 5'd17, 5'd9, 2'b10), 16'h0BAD, 1'b1, 1'b0, got, pre, post);
    preamble(32, 1'b1);
    run_frame(hdr_of(2'b01, 2'b10, 5'd30, 5'd9, 2'b10), 16'h0, 1'b0, 1'b0, got, pre, post);
    chk("R8 address ignored", 32'(got), 32'h0BAD);

    // R7: reset restores the identifier words and clears written entries
    @(negedge clk); rst_n = 1'b0; mdc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 mdio_out after reset", 32'(mdio_out), 0);
    preamble(32, 1'b1);
    run_frame(hdr_of(2'b01, 2'b10, 5'd0, 5'd2, 2'b10), 16'h0, 1'b0, 1'b0, got, pre, post);
    chk("R7 entry 2 reset", 32'(got), 32'h0022);
    preamble(32, 1'b1);
    run_frame(hdr_of(2'b01, 2'b10, 5'd0, 5'd3, 2'b10), 16'h0, 1'b0, 1'b0, got, pre, post);
    chk("R7 entry 3 reset", 32'(got), 32'h161A);
    preamble(32, 1'b1);
    run_frame(hdr_of(2'b01, 2'b10, 5'd0, 5'd5, 2'b10), 16'h0, 1'b0, 1'b0, got, pre, post);
    chk("R7 entry 5 cleared", 32'(got), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule